// File: doc/BRIEF.md
# SPI Slave Byte Engine with Holding Registers

This block is the target side of an SPI link. A remote controller drives the serial clock, the active-low select and the controller-to-target data line; all three reach the block as plain inputs. They are oversampled into the local system clock domain, and edges are detected there. The block therefore needs no clock of its own for the serial side. The local clock must run at least four times faster than the serial clock.

The local bus side sees two byte-wide holding registers. The transmit holding register is write-only and queues the next byte to send. The receive holding register is read-only and shows the last byte that arrived complete. Two flags pace the bus side. `tx_empty` says that a new transmit byte may be written. `rx_full` says that an unread byte is waiting. When the remote controller begins a byte and nothing is queued, the block sends all ones and raises a sticky underrun bit. Clock polarity and phase are chosen by two static configuration inputs. Both sides shift the most significant bit first.

Top module: `spi_slave_dbuf`

## Requirements
- R1: After synchronous reset, `tx_empty`=1, `rx_full`=0, `tx_underrun`=0, `spi_miso_oe`=0 and `rx_rdata`=0x00.
- R2: A `tx_wr` pulse while `tx_empty`=1 stores `tx_wdata` and clears `tx_empty` on the next cycle. A `tx_wr` while `tx_empty`=0 is ignored, and the byte already queued is the one sent next.
- R3: The queued byte moves into the shifter at the start of each byte, and `tx_empty` is set at that moment. With `cfg_cpha`=0 this happens at the fall of select and at the trailing clock edge that ends each byte. With `cfg_cpha`=1 it happens at the first leading clock edge of each byte.
- R4: Data leave on `spi_miso` MSB first. The serial clock idles at `cfg_cpol`. A leading edge leaves that idle level and a trailing edge returns to it. With `cfg_cpha`=0 the input is sampled on leading edges and the output changes on trailing edges. With `cfg_cpha`=1 the output changes on leading edges and the input is sampled on trailing edges.
- R5: The eighth sampled bit of a byte completes it. The byte (first bit as bit 7) then appears on `rx_rdata` and `rx_full` is set. An unread byte is overwritten.
- R6: An `rx_rd` pulse clears `rx_full` on the next cycle, unless a byte completes in the same cycle, in which case `rx_full` stays set.
- R7: If a byte starts while `tx_empty`=1, the byte sent is 0xFF and `tx_underrun` is set. It stays set until reset.
- R8: If select rises before the eighth bit, the bit count restarts at zero, nothing reaches `rx_rdata`, and `rx_full` is unchanged.
- R9: `spi_miso_oe` is low whenever the synchronised select is high, and high while it is low.
- R10: Each serial input passes two synchroniser flops before edge detection. Two serial clock edges are never seen on consecutive system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| spi_sclk | input | 1 | Serial clock from the remote controller |
| spi_sel_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | DW | Byte to queue for sending |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_rdata | output | DW | Last complete received byte |
| tx_empty | output | 1 | Transmit holding register may be written |
| rx_full | output | 1 | Unread received byte present |
| tx_underrun | output | 1 | Sticky: a byte started with nothing queued |

## Verification
Some rules are checked by assertions on every cycle. These cover the flag updates (write clears `tx_empty`, a load sets it, byte completion sets `rx_full`, a read clears it, `tx_underrun` stays set) and the ignored write that leaves the held byte unchanged. They also cover the bit count clearing after select rises, the output enable dropping after deselection, and the spacing between serial clock edges. Other behaviour can only be shown by the bench's scenarios: the bit order on both data lines in all four clock modes, the moment each queued byte is committed, the 0xFF substitution, and an aborted byte being dropped while the next byte is still received intact. The bench shows these by comparing every output on every cycle against its own model and by checking the bytes that its serial controller collects.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  // Per-cycle serial events, derived from the synchronised pins
  typedef struct packed {
    logic active;    // select currently asserted
    logic sel_fall;  // select just asserted
    logic sel_rise;  // select just released
    logic samp;      // take one input bit
    logic shft;      // advance output bit
  } spi_evt_t;

endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_edge_ctl.sv
module spi_edge_ctl
  import spi_slave_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cpol,
  input  logic     cpha,
  input  logic     sclk_s,
  input  logic     sel_n_s,
  output spi_evt_t evt
);

  logic sclk_q, sel_n_q;
  logic toggled, lead, trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sel_n_q <= 1'b1;
    end else begin
      sclk_q  <= sclk_s;
      sel_n_q <= sel_n_s;
    end
  end

  assign toggled = sclk_s ^ sclk_q;
  assign lead    = toggled & (sclk_s ^ cpol);
  assign trail   = toggled & ~(sclk_s ^ cpol);

  always_comb begin
    evt.active   = ~sel_n_s;
    evt.sel_fall = ~sel_n_s & sel_n_q;
    evt.sel_rise = sel_n_s & ~sel_n_q;
    evt.samp     = ~sel_n_s & (cpha ? trail : lead);
    evt.shft     = ~sel_n_s & (cpha ? lead : trail);
  end

  // R10: the system clock oversamples, so clock edges are never back to back
  assert_sclk_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    (sclk_s != sclk_q) |=> (sclk_s == sclk_q));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slave_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpha,
  input  spi_evt_t      evt,
  input  logic          mosi_s,
  input  logic [DW-1:0] hold_byte,
  input  logic          hold_empty,
  output logic          miso_bit,
  output logic          consume,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);

  localparam int            CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] tx_sh, rx_sh;
  logic [CW-1:0] cnt;

  assign consume   = evt.active & ((evt.sel_fall & ~cpha) | (evt.shft & (cnt == '0)));
  assign byte_done = evt.samp & (cnt == LAST);
  assign rx_byte   = {rx_sh[DW-2:0], mosi_s};
  assign miso_bit  = tx_sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '1;
      rx_sh <= '0;
      cnt   <= '0;
    end else begin
      if (consume)       tx_sh <= hold_empty ? '1 : hold_byte;
      else if (evt.shft) tx_sh <= {tx_sh[DW-2:0], 1'b1};

      if (evt.sel_rise) begin
        cnt <= '0;
      end else if (evt.samp) begin
        rx_sh <= rx_byte;
        cnt   <= (cnt == LAST) ? '0 : cnt + CW'(1);
      end
    end
  end

  // R8: a released select restarts the bit count
  assert_abort_clears_count_R8: assert property (@(posedge clk) disable iff (rst)
    evt.sel_rise |=> (cnt == '0));

endmodule

// File: rtl/spi_hold_regs.sv
module spi_hold_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_rd,
  input  logic          consume,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] tx_hold,
  output logic          tx_empty,
  output logic [DW-1:0] rx_hold,
  output logic          rx_full,
  output logic          underrun
);

  logic wr_ok;
  assign wr_ok = tx_wr & tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold  <= '0;
      tx_empty <= 1'b1;
      underrun <= 1'b0;
    end else begin
      if (consume & tx_empty) underrun <= 1'b1;
      if (consume)            tx_empty <= 1'b1;
      if (wr_ok) begin
        tx_hold  <= tx_wdata;
        tx_empty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
    end else if (byte_done) begin
      rx_hold <= rx_byte;
      rx_full <= 1'b1;
    end else if (rx_rd) begin
      rx_full <= 1'b0;
    end
  end

  assert_write_clears_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && tx_empty) |=> !tx_empty);
  assert_blocked_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !tx_empty) |=> $stable(tx_hold));
  assert_load_sets_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (consume && !(tx_wr && tx_empty)) |=> tx_empty);
  assert_done_sets_full_R5: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> rx_full);
  assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !byte_done) |=> !rx_full);
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

endmodule

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf
  import spi_slave_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          spi_sclk,
  input  logic          spi_sel_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          tx_underrun
);

  logic [2:0]    pins_s;
  logic          sclk_s, sel_n_s, mosi_s;
  spi_evt_t      evt;
  logic [DW-1:0] tx_hold, rx_byte;
  logic          consume, byte_done, oe_q;

  spi_sync_bank #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sel_n, spi_sclk, spi_mosi}),
    .q   (pins_s)
  );

  assign sel_n_s = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign mosi_s  = pins_s[0];

  spi_edge_ctl u_edge (
    .clk     (clk),
    .rst     (rst),
    .cpol    (cfg_cpol),
    .cpha    (cfg_cpha),
    .sclk_s  (sclk_s),
    .sel_n_s (sel_n_s),
    .evt     (evt)
  );

  spi_shift_core #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cpha       (cfg_cpha),
    .evt        (evt),
    .mosi_s     (mosi_s),
    .hold_byte  (tx_hold),
    .hold_empty (tx_empty),
    .miso_bit   (spi_miso),
    .consume    (consume),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte)
  );

  spi_hold_regs #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .tx_wr     (tx_wr),
    .tx_wdata  (tx_wdata),
    .rx_rd     (rx_rd),
    .consume   (consume),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_hold   (tx_hold),
    .tx_empty  (tx_empty),
    .rx_hold   (rx_rdata),
    .rx_full   (rx_full),
    .underrun  (tx_underrun)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~sel_n_s;
  end
  assign spi_miso_oe = oe_q;

  // R9: pad driver released once select is seen high
  assert_oe_off_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !spi_miso_oe);

endmodule

// File: tb/spi_slave_dbuf_test.sv
module spi_slave_dbuf_test;

  localparam int H = 4;  // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst, cpol, cpha, sclk, sel_n, mosi, tx_wr, rx_rd;
  logic [7:0] tx_wdata;
  logic       miso, miso_oe, tx_empty, rx_full, tx_underrun;
  logic [7:0] rx_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_slave_dbuf uut (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .spi_sclk(sclk), .spi_sel_n(sel_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_underrun(tx_underrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // Pins are seen two system edges late (R10); edges compare against three edges ago.
  bit   h1_c, h2_c, h3_c, h1_s, h2_s, h3_s, h1_m, h2_m;
  logic [7:0] m_obyte, m_hold, m_rx;
  int   m_idx, m_bit, m_acc;
  bit   m_empty, m_full, m_under, m_oe;

  always @(posedge clk) begin
    bit lead, trail, act, samp, shf, rise, fall, cons, done, we;
    if (rst) begin
      h1_c = 0; h2_c = 0; h3_c = 0; h1_s = 1; h2_s = 1; h3_s = 1; h1_m = 0; h2_m = 0;
      m_obyte = 8'hFF; m_idx = 7; m_bit = 0; m_acc = 0; m_hold = 0; m_rx = 0;
      m_empty = 1; m_full = 0; m_under = 0; m_oe = 0;
    end else begin
      lead  = (h2_c != h3_c) && (h2_c != cpol);
      trail = (h2_c != h3_c) && (h2_c == cpol);
      act   = !h2_s;
      rise  = h2_s && !h3_s;
      fall  = !h2_s && h3_s;
      samp  = act && (cpha ? trail : lead);
      shf   = act && (cpha ? lead : trail);
      cons  = act && ((fall && !cpha) || (shf && m_bit == 0));
      done  = 0;
      if (rise) m_bit = 0;
      else if (act) begin
        if (cons) begin m_obyte = m_empty ? 8'hFF : m_hold; m_idx = 7; end
        else if (shf) m_idx = m_idx - 1;
        if (samp) begin
          m_acc = (m_acc * 2 + int'(h2_m)) % 256;
          if (m_bit == 7) begin done = 1; m_bit = 0; end else m_bit = m_bit + 1;
        end
      end
      if (cons && m_empty) m_under = 1;
      we = tx_wr && m_empty;
      if (cons) m_empty = 1;
      if (we) begin m_hold = tx_wdata; m_empty = 0; end
      if (done) begin m_rx = 8'(m_acc); m_full = 1; end
      else if (rx_rd) m_full = 0;
      m_oe = act;
      h3_c = h2_c; h2_c = h1_c; h1_c = sclk;
      h3_s = h2_s; h2_s = h1_s; h1_s = sel_n;
      h2_m = h1_m; h1_m = mosi;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R3 tx_empty", tx_empty, m_empty);
      chk("R5/R6 rx_full", rx_full, m_full);
      chk("R5 rx_rdata", rx_rdata, m_rx);
      chk("R7 tx_underrun", tx_underrun, m_under);
      chk("R9 miso_oe", miso_oe, m_oe);
      if (m_oe) chk("R4 miso", miso, m_obyte[m_idx]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic pol, input logic pha);
    rst = 1; cpol = pol; cpha = pha; sclk = pol; sel_n = 1; mosi = 0;
    tx_wr = 0; rx_rd = 0; tx_wdata = 0;
    wait_cyc(4);
    rst = 0;
    wait_cyc(1);
  endtask

  task automatic bus_write(input logic [7:0] d);
    tx_wdata = d; tx_wr = 1;
    wait_cyc(1);
    tx_wr = 0;
    wait_cyc(1);
  endtask

  task automatic bus_read(input logic [7:0] exp, input string tag);
    chk(tag, rx_rdata, exp);
    rx_rd = 1;
    wait_cyc(1);
    rx_rd = 0;
    chk("R6 rx_full after read", rx_full, 0);
    wait_cyc(1);
  endtask

  // Serial controller: sends mo MSB first for nbits bits, collects mi
  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = mo[i];
        wait_cyc(H);
        sclk = ~cpol; mi[i] = miso;
        wait_cyc(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = mo[i];
        wait_cyc(H);
        sclk = cpol; mi[i] = miso;
        wait_cyc(H);
      end
    end
    wait_cyc(H);
  endtask

  logic [7:0] got;

  initial begin
    // R1: reset state
    do_reset(0, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_underrun", tx_underrun, 0);
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 rx_rdata", rx_rdata, 8'h00);

    // Mode 0: two bytes, preloading, blocked write (R2, R3, R4, R5)
    bus_write(8'hA5);
    chk("R2 tx_empty after write", tx_empty, 0);
    sel_n = 0;
    wait_cyc(H);
    chk("R3 tx_empty after select fall", tx_empty, 1);
    bus_write(8'h5A);
    bus_write(8'h11);               // R2: must be ignored
    xfer(8'h3C, 8, got);
    chk("R4 mode0 byte1 out", got, 8'hA5);
    bus_read(8'h3C, "R5 mode0 byte1 in");
    bus_write(8'h77);
    xfer(8'hC3, 8, got);
    chk("R2 queued byte kept", got, 8'h5A);
    sel_n = 1;
    wait_cyc(H);
    bus_read(8'hC3, "R5 mode0 byte2 in");
    chk("R7 no underrun when queued", tx_underrun, 0);

    // Mode 3: load at first leading edge (R3, R4)
    do_reset(1, 1);
    bus_write(8'h96);
    sel_n = 0;
    wait_cyc(H);
    chk("R3 mode3 still queued", tx_empty, 0);
    xfer(8'hE1, 8, got);
    chk("R4 mode3 byte1 out", got, 8'h96);
    bus_write(8'h69);
    xfer(8'h0F, 8, got);
    chk("R4 mode3 byte2 out", got, 8'h69);
    sel_n = 1;
    wait_cyc(H);
    chk("R5 mode3 last byte", rx_rdata, 8'h0F);
    chk("R5 overwrite keeps full", rx_full, 1);
    chk("R7 mode3 no underrun", tx_underrun, 0);

    // Mode 1: underrun (R7)
    do_reset(0, 1);
    sel_n = 0;
    wait_cyc(H);
    xfer(8'h55, 8, got);
    chk("R7 underrun byte is FF", got, 8'hFF);
    chk("R7 underrun set", tx_underrun, 1);
    sel_n = 1;
    wait_cyc(H);
    bus_read(8'h55, "R5 mode1 byte in");
    bus_write(8'h12);
    sel_n = 0;
    wait_cyc(H);
    xfer(8'hAA, 8, got);
    chk("R4 mode1 byte out", got, 8'h12);
    chk("R7 underrun sticky", tx_underrun, 1);
    sel_n = 1;
    wait_cyc(H);
    bus_read(8'hAA, "R5 mode1 second byte in");

    // Mode 2: aborted byte (R8)
    do_reset(1, 0);
    bus_write(8'h81);
    sel_n = 0;
    wait_cyc(H);
    xfer(8'hF0, 4, got);
    chk("R4 partial out", got, 8'h80);
    sel_n = 1;
    wait_cyc(2 * H);
    chk("R8 aborted byte not delivered", rx_full, 0);
    chk("R8 rx_rdata untouched", rx_rdata, 8'h00);
    chk("R9 oe released", miso_oe, 0);
    sel_n = 0;
    wait_cyc(H);
    xfer(8'hC5, 8, got);
    chk("R7 empty at select fall gives FF", got, 8'hFF);
    sel_n = 1;
    wait_cyc(H);
    bus_read(8'hC5, "R8 next byte intact");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule